// File: doc/BRIEF.md
# 64-bit Execution Unit with Condition Flags

This block is the arithmetic and logic stage of a 64-bit core. Two 64-bit operands and a 4-bit operation select go in. A 64-bit result and four condition flags come out within the same cycle. The flags are negative, zero, carry and overflow.

A flag-load input decides whether those flags are captured into a 4-bit flags register on the rising clock edge. Flag-setting add and subtract instructions drive it high. Every other instruction leaves it low, so the held flags survive until a later conditional branch reads them.

Memory instructions use the add operation to form an address from a base and an offset. Register and immediate arithmetic use the full set of operations. Multiplication keeps only the low 64 bits of the product.

The flags register is the only state. It has two conditions:
- **HOLD**: the flag-load input is low, and the register keeps its value.
- **LOAD**: the flag-load input is high, and the register captures the current flags at the clock edge.

An active-low asynchronous reset forces the register to zero.

Top module: `exec_alu64`

## Requirements
- R1: Select 0010 returns A+B. Select 0110 returns A-B, computed as A + ~B + 1. For both, C is the carry out of bit 63 and V is set on signed overflow.
- R2: Bitwise operations use these selects: 0000 is AND, 0001 is OR, 0100 is XOR and 1100 is NOR.
- R3: Select 0011 returns the low 64 bits of A*B.
- R4: Select 0111 returns operand B unchanged.
- R5: Select 1000 shifts A left and select 1001 shifts A right (logical, zero fill). The shift amount is bits [5:0] of B, and the upper bits of B have no effect.
- R6: Select 1111 (no operation) and every unassigned select (0101, 1010, 1011, 1101, 1110) return zero.
- R7: The N flag equals result bit 63. The Z flag is 1 exactly when the result is all zeros.
- R8: For any select other than 0010 and 0110, C and V are 0.
- R9: flags_q is {N,Z,C,V}, with N in bit 3 and V in bit 0. It loads the current flags at a rising edge when set_flags is high, and holds otherwise.
- R10: While rst_n is low, flags_q is 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flags register |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand, or shift amount |
| op_sel | input | 4 | Operation select |
| set_flags | input | 1 | Load the flags register at the next edge |
| result | output | 64 | Operation result |
| res_n | output | 1 | Negative flag of the current result |
| res_z | output | 1 | Zero flag of the current result |
| res_c | output | 1 | Carry flag of the current result |
| res_v | output | 1 | Overflow flag of the current result |
| flags_q | output | 4 | Held flags {N,Z,C,V} |

## Verification
The assertions check the following on every cycle:
- the LOAD and HOLD behaviour of the flags register;
- the reset value of the flags register;
- a zero result from the no-operation select;
- that carry and overflow stay clear outside add and subtract;
- pass-through of B;
- agreement between the zero flag and the result.

The arithmetic values themselves can only be shown by the bench's scenarios. These cover:
- carries and signed overflow at the 64-bit edges;
- truncated products;
- shift amounts that carry junk in the upper bits of B;
- sequences where held flags must survive several non-flag-setting instructions.

// File: rtl/alu_pkg.sv
package alu_pkg;
    localparam int DATA_W = 64;

    typedef enum logic [3:0] {
        SEL_AND  = 4'b0000,
        SEL_OR   = 4'b0001,
        SEL_ADD  = 4'b0010,
        SEL_MUL  = 4'b0011,
        SEL_XOR  = 4'b0100,
        SEL_SUB  = 4'b0110,
        SEL_PASS = 4'b0111,
        SEL_SHL  = 4'b1000,
        SEL_SHR  = 4'b1001,
        SEL_NOR  = 4'b1100,
        SEL_NOP  = 4'b1111
    } alu_sel_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } cond_flags_t;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         carry,
    output logic         ovf
);
    logic [W-1:0] b_eff;
    logic [W:0]   wide;

    always_comb begin
        // Subtraction reuses the adder: invert B and feed the +1 in as carry-in.
        b_eff = sub ? ~b : b;
        wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
        sum   = wide[W-1:0];
        carry = wide[W];
        // Signed overflow: both addends share a sign that the sum does not.
        ovf   = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
    end
endmodule

// File: rtl/alu_bitops.sv
module alu_bitops
    import alu_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [3:0]   sel,
    output logic [W-1:0] res
);
    localparam int SHW = $clog2(W);

    logic [SHW-1:0] amt;
    assign amt = b[SHW-1:0];

    always_comb begin
        case (sel)
            SEL_AND:  res = a & b;
            SEL_OR:   res = a | b;
            SEL_XOR:  res = a ^ b;
            SEL_NOR:  res = ~(a | b);
            SEL_MUL:  res = a * b;
            SEL_PASS: res = b;
            SEL_SHL:  res = a << amt;
            SEL_SHR:  res = a >> amt;
            default:  res = '0;
        endcase
    end
endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
    import alu_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  cond_flags_t d,
    output cond_flags_t q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end
endmodule

// File: rtl/exec_alu64.sv
module exec_alu64
    import alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    input  logic [3:0]   op_sel,
    input  logic         set_flags,
    output logic [W-1:0] result,
    output logic         res_n,
    output logic         res_z,
    output logic         res_c,
    output logic         res_v,
    output logic [3:0]   flags_q
);
    logic [W-1:0] sum;
    logic [W-1:0] bit_res;
    logic         carry;
    logic         ovf;
    logic         is_arith;
    cond_flags_t  cur;
    cond_flags_t  held;

    assign is_arith = (op_sel == SEL_ADD) || (op_sel == SEL_SUB);

    alu_addsub #(.W(W)) u_addsub (
        .a     (op_a),
        .b     (op_b),
        .sub   (op_sel == SEL_SUB),
        .sum   (sum),
        .carry (carry),
        .ovf   (ovf)
    );

    alu_bitops #(.W(W)) u_bitops (
        .a   (op_a),
        .b   (op_b),
        .sel (op_sel),
        .res (bit_res)
    );

    always_comb begin
        result = is_arith ? sum : bit_res;
        cur.n  = result[W-1];
        cur.z  = ~|result;
        cur.c  = is_arith & carry;
        cur.v  = is_arith & ovf;
    end

    alu_flag_reg u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (set_flags),
        .d     (cur),
        .q     (held)
    );

    assign res_n   = cur.n;
    assign res_z   = cur.z;
    assign res_c   = cur.c;
    assign res_v   = cur.v;
    assign flags_q = held;
endmodule

// File: rtl/exec_alu64_chk.sv
module exec_alu64_chk #(
    parameter int W = 64
) (
    input logic         clk,
    input logic         rst_n,
    input logic [W-1:0] op_b,
    input logic [3:0]   op_sel,
    input logic         set_flags,
    input logic [W-1:0] result,
    input logic         res_n,
    input logic         res_z,
    input logic         res_c,
    input logic         res_v,
    input logic [3:0]   flags_q
);
    assert_flags_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        set_flags |=> flags_q == $past({res_n, res_z, res_c, res_v}));

    assert_flags_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !set_flags |=> $stable(flags_q));

    assert_reset_clear_R10: assert property (@(posedge clk)
        !rst_n |-> flags_q == 4'b0000);

    assert_nop_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        op_sel == 4'b1111 |-> (result == '0) && res_z);

    assert_pass_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
        op_sel == 4'b0111 |-> result == op_b);

    assert_cv_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_sel != 4'b0010 && op_sel != 4'b0110) |-> !res_c && !res_v);

    assert_zero_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        res_z == (result == '0));
endmodule

bind exec_alu64 exec_alu64_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_b      (op_b),
    .op_sel    (op_sel),
    .set_flags (set_flags),
    .result    (result),
    .res_n     (res_n),
    .res_z     (res_z),
    .res_c     (res_c),
    .res_v     (res_v),
    .flags_q   (flags_q)
);

// File: tb/tb_exec_alu64.sv
module tb_exec_alu64;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] op_a = '0;
    logic [63:0] op_b = '0;
    logic [3:0]  op_sel = 4'hF;
    logic        set_flags = 1'b0;
    logic [63:0] result;
    logic        res_n, res_z, res_c, res_v;
    logic [3:0]  flags_q;

    int checks = 0;
    int fails = 0;
    logic [3:0] model_flags = 4'b0000;

    always #(CLK_PERIOD/2) clk = ~clk;

    exec_alu64 dut (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .op_sel(op_sel),
        .set_flags(set_flags), .result(result), .res_n(res_n), .res_z(res_z),
        .res_c(res_c), .res_v(res_v), .flags_q(flags_q)
    );

    // Behavioural reference model.
    task automatic model(input logic [3:0] s, input logic [63:0] a, input logic [63:0] b,
                         output logic [63:0] r, output logic [3:0] f, output string tag);
        logic [64:0] w;
        logic c, v;
        c = 1'b0;
        v = 1'b0;
        case (s)
            4'b0010: begin
                w = {1'b0, a} + {1'b0, b};
                r = w[63:0];
                c = w[64];
                v = (a[63] == b[63]) && (r[63] != a[63]);
                tag = "R1";
            end
            4'b0110: begin
                w = {1'b0, a} + {1'b0, ~b} + 65'd1;
                r = w[63:0];
                c = w[64];
                v = (a[63] != b[63]) && (r[63] != a[63]);
                tag = "R1";
            end
            4'b0000: begin r = a & b;    tag = "R2"; end
            4'b0001: begin r = a | b;    tag = "R2"; end
            4'b0100: begin r = a ^ b;    tag = "R2"; end
            4'b1100: begin r = ~(a | b); tag = "R2"; end
            4'b0011: begin r = a * b;    tag = "R3"; end
            4'b0111: begin r = b;        tag = "R4"; end
            4'b1000: begin r = a << b[5:0]; tag = "R5"; end
            4'b1001: begin r = a >> b[5:0]; tag = "R5"; end
            default: begin r = '0;       tag = "R6"; end
        endcase
        f = {r[63], (r == 64'd0), c, v};
    endtask

    task automatic apply(input logic [3:0] s, input logic [63:0] a, input logic [63:0] b,
                         input logic sf);
        logic [63:0] er;
        logic [3:0]  ef;
        string       tag;
        @(negedge clk);
        // Held flags reflect all loads up to the previous edge (R9).
        checks++;
        if (flags_q !== model_flags) begin
            fails++;
            $display("FAIL R9 flags_q actual=%b expected=%b", flags_q, model_flags);
        end
        op_sel = s;
        op_a = a;
        op_b = b;
        set_flags = sf;
        #1;
        model(s, a, b, er, ef, tag);
        checks++;
        if (result !== er) begin
            fails++;
            $display("FAIL %s sel=%b result actual=%h expected=%h", tag, s, result, er);
        end
        checks++;
        if ({res_n, res_z, res_c, res_v} !== ef) begin
            fails++;
            $display("FAIL R7 R8 sel=%b flags actual=%b expected=%b", s,
                     {res_n, res_z, res_c, res_v}, ef);
        end
        if (sf) model_flags = ef;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // R10: reset value.
        #(CLK_PERIOD * 2 + 2);
        checks++;
        if (flags_q !== 4'b0000) begin
            fails++;
            $display("FAIL R10 flags_q actual=%b expected=0000", flags_q);
        end
        // Loads are ignored while reset is held.
        set_flags = 1'b1;
        op_sel = 4'b0110;
        op_a = 64'd0;
        op_b = 64'd1;
        @(posedge clk);
        #2;
        checks++;
        if (flags_q !== 4'b0000) begin
            fails++;
            $display("FAIL R10 flags_q in reset actual=%b expected=0000", flags_q);
        end
        set_flags = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;

        // R1: add and subtract at the edges.
        apply(4'b0010, 64'd5, 64'd7, 1'b0);
        apply(4'b0010, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 1'b1);   // carry out, zero result
        apply(4'b0010, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 1'b1);   // signed overflow
        apply(4'b0110, 64'd3, 64'd9, 1'b1);                     // borrow: C=0, negative
        apply(4'b0110, 64'd9, 64'd9, 1'b0);                     // equal: Z=1, C=1
        apply(4'b0110, 64'h8000_0000_0000_0000, 64'd1, 1'b1);   // signed overflow on subtract

        // R2: bitwise operations.
        apply(4'b0000, 64'hF0F0_1234_5678_9ABC, 64'h0FF0_FFFF_0000_FFFF, 1'b0);
        apply(4'b0001, 64'hF0F0_0000_0000_0000, 64'h0000_0000_0000_000F, 1'b0);
        apply(4'b0100, 64'hAAAA_AAAA_AAAA_AAAA, 64'hAAAA_AAAA_AAAA_AAAA, 1'b0);
        apply(4'b1100, 64'd0, 64'd0, 1'b1);                     // all ones: N=1, C=V=0

        // R3: multiply, low half only.
        apply(4'b0011, 64'd12345, 64'd678, 1'b0);
        apply(4'b0011, 64'h1_0000_0001, 64'h1_0000_0000, 1'b0);
        apply(4'b0011, 64'hFFFF_FFFF_FFFF_FFFF, 64'd3, 1'b1);

        // R4: pass B.
        apply(4'b0111, 64'h1111, 64'hDEAD_BEEF_0000_0001, 1'b0);

        // R5: shifts, amount from B[5:0] only.
        apply(4'b1000, 64'd1, 64'd63, 1'b0);
        apply(4'b1000, 64'd1, 64'hFFFF_FF00_0000_0044, 1'b0);   // amount 4
        apply(4'b1001, 64'h8000_0000_0000_0000, 64'd63, 1'b0);
        apply(4'b1001, 64'hFFFF_FFFF_FFFF_FFFF, 64'h40, 1'b0);  // amount 0

        // R6: no operation and unassigned selects.
        apply(4'b1111, 64'd55, 64'd66, 1'b1);
        for (int k = 0; k < 5; k++) begin
            logic [3:0] s;
            case (k)
                0: s = 4'b0101;
                1: s = 4'b1010;
                2: s = 4'b1011;
                3: s = 4'b1101;
                default: s = 4'b1110;
            endcase
            apply(s, 64'hFFFF, 64'hFFFF, 1'b0);
        end

        // R9: load, then hold across several non-flag-setting operations.
        apply(4'b0110, 64'd1, 64'd2, 1'b1);
        apply(4'b0010, 64'd0, 64'd0, 1'b0);
        apply(4'b0111, 64'd0, 64'd4, 1'b0);
        apply(4'b0110, 64'd4, 64'd4, 1'b0);
        apply(4'b0010, 64'd1, 64'd1, 1'b1);
        apply(4'b1111, 64'd0, 64'd0, 1'b0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule